// File: doc/BRIEF.md
# Converter Conversion Controller

This block is the register front end for an eight-input, 10-bit successive-approximation converter. Software uses a simple 32-bit word-addressed register bus to pick an input, power the converter up or down, launch single conversions, and read the result. The result registers hold the conversion value, a completion flag, the input that was actually sampled and a running count of completed conversions.

On the converter side the block drives a power-down level, an input select and a one-cycle launch pulse. It takes back a one-cycle valid strobe together with the 10-bit result. After the converter is powered up, the block waits a fixed settling time before it sends any launch. A launch request that is written while the converter settles, or while a conversion is still running, is kept and sent as soon as the converter is free. A launch request that is written while the converter is powered down is dropped.

Top module: `sar_ctl`

## Requirements
- R1: After reset, core_pd is 1. The configuration, result, flag, sampled-input and count words read 0, the power word reads 1, and the state field of the diagnostic word reads 0.
- R2: Registers are selected by bus_addr[5:2], and bus_addr[1:0] is ignored. The word addresses are: configuration 0x00, result 0x04, completion flag 0x08, sampled input 0x0C, power 0x10, diagnostic 0x14, count 0x20. Any other word reads 0. In the configuration word, bits [2:0] select the input, bit 4 requests a launch and bit 5 selects single mode. Bits [2:0] and bit 5 read back as written.
- R3: Writing 0 to bit 0 of the power word powers the converter up. No launch pulse appears until at least SETTLE_CYC clocks (default 8) after that write. A launch request written during this window reads back as pending (bit 4 = 1) and is sent when the window ends.
- R4: While bit 0 of the power word is 1, writing the launch bit has no effect. Bit 4 reads back 0, the completion flag keeps its value and no launch pulse appears.
- R5: A launch request produces a core_start pulse exactly one cycle wide, with core_chan equal to the selected input. After the launch, bit 4 of the configuration word reads 0.
- R6: The completion flag (bit 0 at 0x08) clears when a launch is sent and sets when core_valid returns. The result word holds the 10-bit value in bits [9:0] and reads 0 in bits [31:10].
- R7: The sampled-input word (bits [2:0] at 0x0C) reports the input used by the launch that completed. This holds even if the configuration input is rewritten while the conversion runs.
- R8: The count word at 0x20 increases by one for each completed conversion and wraps modulo 2^CNT_W.
- R9: Powering down during a conversion abandons it. A later core_valid is ignored, the flag stays 0 and the count and result do not change.
- R10: Bits [1:0] of the diagnostic word give the controller state: 0 powered down, 1 settling, 2 idle, 3 converting.
- R11: A launch request written while a conversion runs is kept. It is sent after the running conversion completes, so both conversions complete in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (6) | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| core_pd | output | 1 | Converter power-down level |
| core_chan | output | 3 | Input select for the running conversion |
| core_start | output | 1 | One-cycle launch pulse |
| core_valid | input | 1 | One-cycle result strobe from the converter |
| core_data | input | 10 | Conversion result |

## Verification
The assertions check these rules on every cycle:
- No launch pulse comes before the settling time has passed since power-up.
- Each launch pulse lasts one cycle, and the completion flag is low while it is high.
- The input select does not change while a conversion runs.
- The count changes only on a completion, and then by exactly one.
- A powered-down converter always returns the controller to its off state.

Other behaviour needs the bench's scenarios. These include dropping a launch written while powered down, keeping a launch written during settling or during a conversion, reporting the launched input after the configuration is rewritten, abandoning a conversion on power-down, and the wrap of the count.

// File: rtl/sar_ctl_pkg.sv
package sar_ctl_pkg;

    localparam int DATA_W = 32;
    localparam int CH_W   = 3;
    localparam int RES_W  = 10;

    // word indices (byte address / 4)
    localparam int W_CFG  = 0;
    localparam int W_DATA = 1;
    localparam int W_EOC  = 2;
    localparam int W_SAMP = 3;
    localparam int W_PWR  = 4;
    localparam int W_DBG  = 5;
    localparam int W_CNT  = 8;

    // configuration bit positions
    localparam int B_START  = 4;
    localparam int B_SINGLE = 5;

    typedef enum logic [1:0] {
        PH_OFF    = 2'd0,
        PH_SETTLE = 2'd1,
        PH_IDLE   = 2'd2,
        PH_CONV   = 2'd3
    } phase_e;

    typedef struct packed {
        logic            single;
        logic            start;
        logic [CH_W-1:0] ch;
    } cfg_t;

    function automatic cfg_t cfg_from_word(input logic [DATA_W-1:0] w);
        cfg_t c;
        c.single = w[B_SINGLE];
        c.start  = w[B_START];
        c.ch     = w[CH_W-1:0];
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] cfg_to_word(input cfg_t c);
        logic [DATA_W-1:0] w;
        w           = '0;
        w[CH_W-1:0] = c.ch;
        w[B_START]  = c.start;
        w[B_SINGLE] = c.single;
        return w;
    endfunction

endpackage

// File: rtl/sar_ctl_regs.sv
module sar_ctl_regs
    import sar_ctl_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              launch,
    input  logic              done,
    input  logic [CH_W-1:0]   done_ch,
    input  logic [RES_W-1:0]  core_data,
    output cfg_t              cfg_q,
    output logic              pd_q,
    output logic              eoc_q,
    output logic [RES_W-1:0]  res_q,
    output logic [CH_W-1:0]   samp_q,
    output logic [CNT_W-1:0]  cnt_q
);

    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0] widx;
    logic             wr_cfg;
    logic             wr_pwr;
    cfg_t             cfg_in;

    assign widx   = bus_addr[ADDR_W-1:2];
    assign wr_cfg = bus_en && bus_we && (widx == IDX_W'(W_CFG));
    assign wr_pwr = bus_en && bus_we && (widx == IDX_W'(W_PWR));
    assign cfg_in = cfg_from_word(bus_wdata);

    logic unused_regs;
    assign unused_regs = ^{bus_addr[1:0], bus_wdata[DATA_W-1:B_SINGLE+1], bus_wdata[3]};

    // configuration: a launch request is only accepted while powered
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (wr_cfg) begin
            cfg_q.ch     <= cfg_in.ch;
            cfg_q.single <= cfg_in.single;
            cfg_q.start  <= cfg_in.start && !pd_q;
        end else if (launch || pd_q) begin
            cfg_q.start  <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pd_q <= 1'b1;
        end else if (wr_pwr) begin
            pd_q <= bus_wdata[0];
        end
    end

    // completion capture
    always_ff @(posedge clk) begin
        if (rst) begin
            eoc_q  <= 1'b0;
            res_q  <= '0;
            samp_q <= '0;
            cnt_q  <= '0;
        end else if (launch) begin
            eoc_q  <= 1'b0;
        end else if (done) begin
            eoc_q  <= 1'b1;
            res_q  <= core_data;
            samp_q <= done_ch;
            cnt_q  <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/sar_ctl_seq.sv
module sar_ctl_seq
    import sar_ctl_pkg::*;
#(
    parameter int SETTLE_CYC = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            pd,
    input  logic            start_req,
    input  logic [CH_W-1:0] req_ch,
    input  logic            core_valid,
    output logic            launch,
    output logic            done,
    output phase_e          phase,
    output logic            core_start,
    output logic [CH_W-1:0] core_chan
);

    localparam int SC_W = $clog2(SETTLE_CYC + 1);

    logic [SC_W-1:0] settle_cnt;
    logic            start_q;

    assign launch     = (phase == PH_IDLE) && start_req && !pd;
    assign done       = (phase == PH_CONV) && core_valid && !pd;
    assign core_start = start_q && !pd;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase      <= PH_OFF;
            settle_cnt <= '0;
            start_q    <= 1'b0;
            core_chan  <= '0;
        end else begin
            start_q <= 1'b0;
            if (pd) begin
                phase <= PH_OFF;
            end else begin
                unique case (phase)
                    PH_OFF: begin
                        phase      <= PH_SETTLE;
                        settle_cnt <= '0;
                    end
                    PH_SETTLE: begin
                        if (settle_cnt == SC_W'(SETTLE_CYC - 1)) begin
                            phase <= PH_IDLE;
                        end else begin
                            settle_cnt <= settle_cnt + 1'b1;
                        end
                    end
                    PH_IDLE: begin
                        if (start_req) begin
                            phase     <= PH_CONV;
                            start_q   <= 1'b1;
                            core_chan <= req_ch;
                        end
                    end
                    PH_CONV: begin
                        if (core_valid) begin
                            phase <= PH_IDLE;
                        end
                    end
                    default: phase <= PH_OFF;
                endcase
            end
        end
    end

endmodule

// File: rtl/sar_ctl.sv
module sar_ctl
    import sar_ctl_pkg::*;
#(
    parameter int ADDR_W     = 6,
    parameter int CNT_W      = 16,
    parameter int SETTLE_CYC = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              core_pd,
    output logic [2:0]        core_chan,
    output logic              core_start,
    input  logic              core_valid,
    input  logic [9:0]        core_data
);

    localparam int IDX_W = ADDR_W - 2;

    cfg_t             cfg_q;
    logic             pd_q;
    logic             eoc_flag;
    logic [RES_W-1:0] res_q;
    logic [CH_W-1:0]  samp_q;
    logic [CNT_W-1:0] conv_cnt;
    logic             launch;
    logic             conv_done;
    phase_e           phase;
    logic [IDX_W-1:0] widx;

    sar_ctl_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_en    (bus_en),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .launch    (launch),
        .done      (conv_done),
        .done_ch   (core_chan),
        .core_data (core_data),
        .cfg_q     (cfg_q),
        .pd_q      (pd_q),
        .eoc_q     (eoc_flag),
        .res_q     (res_q),
        .samp_q    (samp_q),
        .cnt_q     (conv_cnt)
    );

    sar_ctl_seq #(.SETTLE_CYC(SETTLE_CYC)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .pd         (pd_q),
        .start_req  (cfg_q.start),
        .req_ch     (cfg_q.ch),
        .core_valid (core_valid),
        .launch     (launch),
        .done       (conv_done),
        .phase      (phase),
        .core_start (core_start),
        .core_chan  (core_chan)
    );

    assign core_pd = pd_q;
    assign widx    = bus_addr[ADDR_W-1:2];

    always_comb begin
        bus_rdata = '0;
        case (widx)
            IDX_W'(W_CFG):  bus_rdata = cfg_to_word(cfg_q);
            IDX_W'(W_DATA): bus_rdata[RES_W-1:0] = res_q;
            IDX_W'(W_EOC):  bus_rdata[0] = eoc_flag;
            IDX_W'(W_SAMP): bus_rdata[CH_W-1:0] = samp_q;
            IDX_W'(W_PWR):  bus_rdata[0] = pd_q;
            IDX_W'(W_DBG):  bus_rdata[1:0] = phase;
            IDX_W'(W_CNT):  bus_rdata[CNT_W-1:0] = conv_cnt;
            default:        bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/sar_ctl_chk.sv
module sar_ctl_chk
    import sar_ctl_pkg::*;
#(
    parameter int CNT_W      = 16,
    parameter int SETTLE_CYC = 8
) (
    input logic            clk,
    input logic            rst,
    input logic            core_pd,
    input logic            core_start,
    input logic [CH_W-1:0] core_chan,
    input logic            eoc,
    input logic [CNT_W-1:0] cnt,
    input logic            done,
    input phase_e          conv_phase
);

    localparam int UP_W = $clog2(SETTLE_CYC + 2);

    // clocks spent powered up, saturating
    logic [UP_W-1:0] up_cnt;
    always_ff @(posedge clk) begin
        if (rst || core_pd) begin
            up_cnt <= '0;
        end else if (up_cnt < UP_W'(SETTLE_CYC)) begin
            up_cnt <= up_cnt + 1'b1;
        end
    end

    // R3: no launch before the settling window has elapsed
    p_settle_r3: assert property (@(posedge clk) disable iff (rst)
        core_start |-> (up_cnt >= UP_W'(SETTLE_CYC)));

    // R5: launch pulse lasts one cycle
    p_start_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        core_start |=> !core_start);

    // R6: flag is clear while a launch is on the wire
    p_eoc_clear_r6: assert property (@(posedge clk) disable iff (rst)
        core_start |-> !eoc);

    // R6: completion raises the flag
    p_eoc_set_r6: assert property (@(posedge clk) disable iff (rst)
        done |=> eoc);

    // R7: input select held for the whole conversion
    p_chan_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (conv_phase == PH_CONV && !core_start) |-> $stable(core_chan));

    // R8: count steps by one on completion
    p_count_step_r8: assert property (@(posedge clk) disable iff (rst)
        done |=> (cnt == CNT_W'($past(cnt) + 1'b1)));

    // R8: count holds otherwise
    p_count_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !done |=> $stable(cnt));

    // R9: power-down forces the off state
    p_pd_off_r9: assert property (@(posedge clk) disable iff (rst)
        core_pd |=> (conv_phase == PH_OFF));

endmodule

bind sar_ctl sar_ctl_chk #(.CNT_W(CNT_W), .SETTLE_CYC(SETTLE_CYC)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .core_pd    (core_pd),
    .core_start (core_start),
    .core_chan  (core_chan),
    .eoc        (eoc_flag),
    .cnt        (conv_cnt),
    .done       (conv_done),
    .conv_phase (phase)
);

// File: tb/test_sar_ctl.sv
module test_sar_ctl;

    localparam int CNT_W  = 4;
    localparam int SETTLE = 8;
    localparam int LAT    = 5;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_en = 1'b0;
    logic        bus_we = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        core_pd;
    logic [2:0]  core_chan;
    logic        core_start;
    logic        core_valid = 1'b0;
    logic [9:0]  core_data = '0;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    int nst = 0;
    int last_start_cyc = 0;
    int tmr = 0;
    logic [9:0] pend_data;
    logic [2:0] log_ch [0:63];

    sar_ctl #(.ADDR_W(6), .CNT_W(CNT_W), .SETTLE_CYC(SETTLE)) i_sar_ctl (
        .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .core_pd(core_pd), .core_chan(core_chan), .core_start(core_start),
        .core_valid(core_valid), .core_data(core_data)
    );

    always #2.5 clk = ~clk;

    function automatic logic [9:0] conv_val(input logic [2:0] ch, input int idx);
        return 10'((int'(ch) * 73 + idx * 151 + 17) & 10'h3FF);
    endfunction

    // behavioural converter stub
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rst) begin
            core_valid <= 1'b0;
            tmr <= 0;
            nst <= 0;
        end else begin
            core_valid <= 1'b0;
            if (core_start) begin
                tmr <= LAT;
                pend_data <= conv_val(core_chan, nst);
                log_ch[nst[5:0]] <= core_chan;
                nst <= nst + 1;
            end else if (tmr != 0) begin
                tmr <= tmr - 1;
                if (tmr == 1) begin
                    core_valid <= 1'b1;
                    core_data <= pend_data;
                end
            end
        end
    end

    always @(negedge clk) if (core_start) last_start_cyc = cyc;

    always @(posedge clk) begin
        if (cyc > 100000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual=%0d expected<=100000 cycles", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, got, exp);
        end
    endtask

    int wr_edge = 0;
    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
        wr_edge = cyc;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_en = 1'b1; bus_we = 1'b0;
        #1 d = bus_rdata;
        bus_en = 1'b0;
    endtask

    task automatic wait_eoc(input string tag);
        logic [31:0] v;
        for (int i = 0; i < 100; i++) begin
            rd(6'h08, v);
            if (v[0]) return;
        end
        chk(tag, 32'd0, 32'd1);
    endtask

    int exp_cnt = 0;
    int exp_st = 0;
    logic [9:0] exp_data = '0;

    task automatic do_conv(input logic [2:0] ch, input logic single);
        logic [31:0] v;
        wr(6'h00, {26'd0, single, 1'b1, 1'b0, ch});
        wait_eoc("R6 completion");
        exp_st++;
        exp_cnt = (exp_cnt + 1) % (1 << CNT_W);
        exp_data = conv_val(ch, exp_st - 1);
        chk("R5 launch count", nst, exp_st);
        chk("R5 core_chan", {29'd0, log_ch[(exp_st - 1) & 63]}, {29'd0, ch});
        rd(6'h04, v); chk("R6 result", v, {22'd0, exp_data});
        rd(6'h0C, v); chk("R7 sampled input", v, {29'd0, ch});
        rd(6'h20, v); chk("R8 count", v, exp_cnt);
        rd(6'h00, v); chk("R5 start self-clear", v, {26'd0, single, 2'b00, ch});
    endtask

    initial begin
        logic [31:0] v;
        int gap;
        void'($urandom(32'd20240611));
        repeat (4) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1 reset state
        chk("R1 core_pd", {31'd0, core_pd}, 32'd1);
        rd(6'h00, v); chk("R1 config", v, 0);
        rd(6'h04, v); chk("R1 result", v, 0);
        rd(6'h08, v); chk("R1 flag", v, 0);
        rd(6'h0C, v); chk("R1 sampled", v, 0);
        rd(6'h20, v); chk("R1 count", v, 0);
        rd(6'h10, v); chk("R1 power", v, 1);
        rd(6'h14, v); chk("R10 diag off", v, 0);
        rd(6'h18, v); chk("R2 unmapped", v, 0);

        // R4 launch while powered down is dropped
        wr(6'h00, 32'h13);
        repeat (15) @(negedge clk);
        rd(6'h00, v); chk("R4 start dropped", v, 32'h03);
        rd(6'h08, v); chk("R4 flag unchanged", v, 0);
        chk("R4 no launch", nst, 0);

        // R3 settling, pending launch
        wr(6'h10, 32'h0);
        gap = wr_edge;
        rd(6'h14, v); chk("R10 diag settling", v, 1);
        wr(6'h00, 32'h35);
        rd(6'h00, v); chk("R3 launch pending", v, 32'h35);
        wait_eoc("R3 completion");
        exp_st++; exp_cnt++;
        gap = last_start_cyc - gap;
        n_chk++;
        if (gap < SETTLE || gap > SETTLE + 2) begin
            n_bad++;
            $display("FAIL R3 settle gap: actual=%0d expected=%0d..%0d", gap, SETTLE, SETTLE + 2);
        end
        rd(6'h00, v); chk("R2 config readback", v, 32'h25);
        rd(6'h0C, v); chk("R7 sampled", v, 5);
        rd(6'h04, v); chk("R6 result", v, {22'd0, conv_val(3'd5, 0)});
        rd(6'h07, v); chk("R2 low address bits ignored", v, {22'd0, conv_val(3'd5, 0)});
        rd(6'h14, v); chk("R10 diag idle", v, 2);

        // R10 converting
        wr(6'h00, 32'h10);
        rd(6'h14, v); chk("R10 diag converting", v, 3);
        wait_eoc("R6 completion");
        exp_st++; exp_cnt++;

        // R7 rewrite of input during conversion
        wr(6'h00, 32'h12);
        wr(6'h00, 32'h06);
        wait_eoc("R7 completion");
        exp_st++; exp_cnt++;
        rd(6'h0C, v); chk("R7 sampled after rewrite", v, 2);
        rd(6'h04, v); chk("R7 result", v, {22'd0, conv_val(3'd2, exp_st - 1)});

        // R11 launch during conversion held
        wr(6'h00, 32'h11);
        wr(6'h00, 32'h14);
        repeat (40) @(negedge clk);
        exp_st += 2; exp_cnt += 2;
        chk("R11 launches", nst, exp_st);
        chk("R11 first input", {29'd0, log_ch[exp_st - 2]}, 1);
        chk("R11 second input", {29'd0, log_ch[exp_st - 1]}, 4);
        rd(6'h0C, v); chk("R11 sampled", v, 4);
        rd(6'h08, v); chk("R11 flag", v, 1);
        rd(6'h20, v); chk("R8 count", v, exp_cnt);

        // random conversions, count wraps
        for (int i = 0; i < 14; i++) begin
            do_conv(3'($urandom_range(0, 7)), 1'($urandom_range(0, 1)));
        end
        rd(6'h20, v); chk("R8 count after wrap", v, (5 + 14) % 16);

        // R4 with flag set
        wr(6'h10, 32'h1);
        wr(6'h00, 32'h13);
        repeat (15) @(negedge clk);
        rd(6'h00, v); chk("R4 start dropped", v, 32'h03);
        rd(6'h08, v); chk("R4 flag kept", v, 1);
        chk("R4 no launch", nst, exp_st);

        // R9 abandon on power-down
        wr(6'h10, 32'h0);
        repeat (12) @(negedge clk);
        wr(6'h00, 32'h17);
        repeat (2) @(negedge clk);
        wr(6'h10, 32'h1);
        repeat (20) @(negedge clk);
        chk("R9 launch issued", nst, exp_st + 1);
        rd(6'h08, v); chk("R9 flag", v, 0);
        rd(6'h20, v); chk("R9 count", v, exp_cnt);
        rd(6'h04, v); chk("R9 result", v, {22'd0, exp_data});
        rd(6'h14, v); chk("R9 diag off", v, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule